// File: doc/BRIEF.md
# I2C Register-Pointer Slave

This block is the serial front end of a small on-chip register bank, reached over a two-wire I2C bus. It runs entirely on the system clock. Both bus lines are oversampled and synchronised, and bus events are recognised from their edges: START, repeated START, STOP and the rising and falling edges of the serial clock. The data line is driven open-drain. The block only ever pulls it low through an output-enable, and the pad or board supplies the high level.

Every transfer begins with an address byte. When the seven address bits match the device address, the block acknowledges that byte and then works in the direction the eighth bit selects. In a write transfer, the first data byte sets an internal register pointer. Each byte after that is stored at the pointed register, and the pointer then advances. In a read transfer, bytes are returned starting at the pointer, which also advances after each byte. The pointer keeps its value between transfers. A read that skips the word-address phase therefore continues from wherever the last access stopped. A repeated START is the normal way to set the pointer and then read back without releasing the bus.

Top module: `i2c_reg_slave`

## Requirements
- R1: A START is recognised when SDA falls while SCL is high, and a STOP when SDA rises while SCL is high. A bus with both lines high is idle.
- R2: The block only changes its SDA output-enable while SCL is low. It never drives SDA high: `sdaOe`=1 pulls the line low, and 0 releases it.
- R3: The first byte after a START is the 7-bit address `1101000` (MSB first) followed by a direction bit, where 0 means write and 1 means read. On a match the block holds SDA low through the whole high phase of the ninth clock.
- R4: When the address does not match, the block gives no acknowledge and never enables SDA until the next START or STOP. It also ignores every data byte in that transfer, so neither the pointer nor any register changes.
- R5: In a write transfer, the first byte after the address is acknowledged and loaded into the register pointer. A byte value at or above the register count loads 0.
- R6: In a write transfer, each later byte is acknowledged and stored at the pointed register, and the pointer then advances by one.
- R7: In a read transfer, bytes go out MSB first, starting at the current pointer, and the pointer advances after each byte. A read with no preceding word-address phase continues from the pointer left by the previous transfer.
- R8: When the master answers a read byte with a not-acknowledge (SDA high on the ninth clock), the block releases SDA and drives nothing more until the next START or STOP.
- R9: A repeated START, given without a STOP, ends the current transfer and begins a new address phase.
- R10: The bank has 16 eight-bit registers. The pointer wraps from register 15 to register 0, in both write and read transfers.
- R11: A STOP returns the block to idle but keeps the pointer value. A synchronous reset clears the pointer and all registers to 0 and releases SDA.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; oversamples the bus |
| rst | input | 1 | Synchronous reset, active high |
| sclIn | input | 1 | Serial clock line level as seen at the pad |
| sdaIn | input | 1 | Serial data line level as seen at the pad |
| sdaOe | output | 1 | Open-drain enable: 1 pulls SDA low, 0 releases it |

## Verification
The bench checks that the pointer persists across a STOP. A read without a word address must return the byte after the last one read. A design that reset the pointer on STOP would return the first register instead. A mismatched address is followed by bytes that would move the pointer and overwrite a register, and a later read exposes any design that acted on them. A write that crosses register 15, followed by a read that crosses the same boundary after two repeated STARTs, shows wrong wrap arithmetic or a missed repeated START. A design that kept driving after the master's not-acknowledge would hold SDA low where the master needs it released. The bench also watches for any change of the SDA enable while SCL is high, which would show up as a false START or STOP on the bus.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,   // waiting for START
    ST_ADDR,   // shifting in address byte
    ST_AACK,   // acknowledging address
    ST_WRX,    // receiving write byte
    ST_WACK,   // acknowledging write byte
    ST_RTX,    // transmitting read byte
    ST_RACK,   // sampling master acknowledge
    ST_SKIP    // ignoring bus until START/STOP
  } ctrlState_t;

  typedef struct packed {
    logic rxShift;   // shift one sampled bit into receive register
    logic txLoad;    // load transmit register from pointed register
    logic txShift;   // advance transmit register by one bit
    logic ptrLoad;   // load pointer from receive register
    logic regWrite;  // store receive register at pointer
    logic ptrInc;    // advance pointer with wrap
  } dpStrobe_t;

endpackage

// File: rtl/i2c_slv_linesync.sv
module i2c_slv_linesync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclHigh,
  output logic sdaNow,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);

  localparam int PIPE_W = SYNC_STAGES + 1;

  logic [PIPE_W-1:0] sclPipe;
  logic [PIPE_W-1:0] sdaPipe;
  logic sclOld;
  logic sdaOld;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclPipe <= '1;
      sdaPipe <= '1;
    end else begin
      sclPipe <= {sclPipe[PIPE_W-2:0], sclIn};
      sdaPipe <= {sdaPipe[PIPE_W-2:0], sdaIn};
    end
  end

  assign sclHigh  = sclPipe[SYNC_STAGES-1];
  assign sdaNow   = sdaPipe[SYNC_STAGES-1];
  assign sclOld   = sclPipe[SYNC_STAGES];
  assign sdaOld   = sdaPipe[SYNC_STAGES];

  assign sclRise  = sclHigh & ~sclOld;
  assign sclFall  = ~sclHigh & sclOld;
  assign startDet = sclHigh & sclOld & sdaOld & ~sdaNow;
  assign stopDet  = sclHigh & sclOld & ~sdaOld & sdaNow;

  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({startDet, stopDet, sclRise, sclFall})); // R1

endmodule

// File: rtl/i2c_slv_dpath.sv
module i2c_slv_dpath
  import i2c_slv_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  dpStrobe_t         stb,
  input  logic              sdaBit,
  output logic [DATA_W-1:0] rxByte,
  output logic              txBit
);

  localparam int PTR_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(NUM_REGS - 1);

  logic [DATA_W-1:0] rxReg;
  logic [DATA_W-1:0] txReg;
  logic [PTR_W-1:0]  ptr;
  logic [DATA_W-1:0] regFile [NUM_REGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      rxReg <= '0;
      txReg <= '0;
    end else begin
      if (stb.rxShift) rxReg <= {rxReg[DATA_W-2:0], sdaBit};
      if (stb.txLoad)       txReg <= regFile[ptr];
      else if (stb.txShift) txReg <= {txReg[DATA_W-2:0], 1'b1};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (stb.ptrLoad) begin
      ptr <= (int'(rxReg) < NUM_REGS) ? rxReg[PTR_W-1:0] : '0;
    end else if (stb.ptrInc) begin
      ptr <= (ptr == PTR_LAST) ? '0 : ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) regFile[i] <= '0;
    end else if (stb.regWrite) begin
      regFile[ptr] <= rxReg;
    end
  end

  assign rxByte = rxReg;
  assign txBit  = txReg[DATA_W-1];

  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (rst)
    (stb.ptrInc && !stb.ptrLoad && ptr == PTR_LAST) |=> (ptr == '0)); // R10

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    stb.regWrite |=> (regFile[$past(ptr)] == $past(rxReg))); // R6

endmodule

// File: rtl/i2c_slv_ctrl.sv
module i2c_slv_ctrl
  import i2c_slv_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b1101000,
  parameter int         DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclHigh,
  input  logic              sdaNow,
  input  logic              sclRise,
  input  logic              sclFall,
  input  logic              startDet,
  input  logic              stopDet,
  input  logic [DATA_W-1:0] rxByte,
  input  logic              txBit,
  output dpStrobe_t         stb,
  output logic              sdaOe
);

  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] BYTE_END = CNT_W'(DATA_W);

  ctrlState_t state;
  logic [CNT_W-1:0] bitCnt;
  logic isRead;
  logic firstWr;
  logic mAck;
  logic byteDone;
  logic addrHit;

  assign byteDone = sclFall && (bitCnt == BYTE_END);
  assign addrHit  = (rxByte[DATA_W-1:1] == DEV_ADDR);

  always_comb begin
    stb = '0;
    case (state)
      ST_ADDR: stb.rxShift = sclRise && (bitCnt != BYTE_END);
      ST_WRX: begin
        stb.rxShift  = sclRise && (bitCnt != BYTE_END);
        stb.ptrLoad  = byteDone && firstWr;
        stb.regWrite = byteDone && !firstWr;
        stb.ptrInc   = byteDone && !firstWr;
      end
      ST_AACK: stb.txLoad = sclFall && isRead;
      ST_RTX: begin
        stb.txShift = sclFall && (bitCnt != BYTE_END);
        stb.ptrInc  = byteDone;
      end
      ST_RACK: stb.txLoad = sclFall && mAck;
      default: stb = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      isRead  <= 1'b0;
      firstWr <= 1'b0;
      mAck    <= 1'b0;
    end else if (stopDet) begin
      state <= ST_IDLE;
    end else if (startDet) begin
      state  <= ST_ADDR;
      bitCnt <= '0;
    end else begin
      case (state)
        ST_ADDR: begin
          if (sclRise && bitCnt != BYTE_END) bitCnt <= bitCnt + 1'b1;
          if (byteDone) begin
            if (addrHit) begin
              state   <= ST_AACK;
              isRead  <= rxByte[0];
              firstWr <= 1'b1;
            end else begin
              state <= ST_SKIP;
            end
          end
        end
        ST_AACK: begin
          if (sclFall) begin
            bitCnt <= '0;
            state  <= isRead ? ST_RTX : ST_WRX;
          end
        end
        ST_WRX: begin
          if (sclRise && bitCnt != BYTE_END) bitCnt <= bitCnt + 1'b1;
          if (byteDone) begin
            state   <= ST_WACK;
            firstWr <= 1'b0;
          end
        end
        ST_WACK: begin
          if (sclFall) begin
            bitCnt <= '0;
            state  <= ST_WRX;
          end
        end
        ST_RTX: begin
          if (sclRise && bitCnt != BYTE_END) bitCnt <= bitCnt + 1'b1;
          if (byteDone) state <= ST_RACK;
        end
        ST_RACK: begin
          if (sclRise) mAck <= ~sdaNow;
          if (sclFall) begin
            bitCnt <= '0;
            state  <= mAck ? ST_RTX : ST_SKIP;
          end
        end
        default: state <= state;
      endcase
    end
  end

  assign sdaOe = (state == ST_AACK) || (state == ST_WACK) ||
                 ((state == ST_RTX) && !txBit);

  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    !$stable(sdaOe) |-> !sclHigh); // R2

  AST_ACK_ONLY_MATCH: assert property (@(posedge clk) disable iff (rst)
    (state == ST_AACK && $past(state) == ST_ADDR) |-> ($past(rxByte[DATA_W-1:1]) == DEV_ADDR)); // R3

  AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SKIP) |-> !sdaOe); // R4

  AST_NACK_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RACK && sclFall && !mAck && !stopDet && !startDet) |=> !sdaOe); // R8

  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (rst)
    stopDet |=> (state == ST_IDLE)); // R11

endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
  import i2c_slv_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'b1101000,
  parameter int         NUM_REGS    = 16,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaOe
);

  localparam int DATA_W = 8;

  logic sclHigh, sdaNow, sclRise, sclFall, startDet, stopDet;
  logic [DATA_W-1:0] rxByte;
  logic txBit;
  dpStrobe_t stb;

  i2c_slv_linesync #(.SYNC_STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rst(rst), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclHigh(sclHigh), .sdaNow(sdaNow), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet)
  );

  i2c_slv_ctrl #(.DEV_ADDR(DEV_ADDR), .DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rst(rst), .sclHigh(sclHigh), .sdaNow(sdaNow),
    .sclRise(sclRise), .sclFall(sclFall), .startDet(startDet), .stopDet(stopDet),
    .rxByte(rxByte), .txBit(txBit), .stb(stb), .sdaOe(sdaOe)
  );

  i2c_slv_dpath #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) uDpath (
    .clk(clk), .rst(rst), .stb(stb), .sdaBit(sdaNow),
    .rxByte(rxByte), .txBit(txBit)
  );

endmodule

// File: tb/sim_i2c_reg_slave.sv
module sim_i2c_reg_slave;

  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;  // system clocks per quarter bit

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mScl = 1'b1;
  logic mSda = 1'b1;
  logic sdaIn;
  logic sdaOe;

  int nChecks = 0;
  int nErrors = 0;
  int oeHigh = 0;
  int edgeViol = 0;
  logic prevOe = 1'b0;
  logic done = 1'b0;

  assign sdaIn = mSda & ~sdaOe;

  i2c_reg_slave u0 (.clk(clk), .rst(rst), .sclIn(mScl), .sdaIn(sdaIn), .sdaOe(sdaOe));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (!rst && (sdaOe !== prevOe) && mScl) edgeViol++;
    if (!rst && sdaOe) oeHigh++;
    prevOe = sdaOe;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart();
    mSda = 1'b1; waitQ();
    mScl = 1'b1; waitQ();
    mSda = 1'b0; waitQ();
    mScl = 1'b0; waitQ();
  endtask

  task automatic busStop();
    mSda = 1'b0; waitQ();
    mScl = 1'b1; waitQ();
    mSda = 1'b1; waitQ();
    waitQ();
  endtask

  task automatic sendBit(input logic b);
    mSda = b; waitQ();
    mScl = 1'b1; waitQ(); waitQ();
    mScl = 1'b0; waitQ();
  endtask

  task automatic getBit(output logic v);
    mSda = 1'b1; waitQ();
    mScl = 1'b1; waitQ();
    v = sdaIn;
    waitQ();
    mScl = 1'b0; waitQ();
  endtask

  task automatic sendByte(input logic [7:0] b, output logic acked);
    logic v;
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    getBit(v);
    acked = ~v;
  endtask

  task automatic recvByte(input logic ackIt, output logic [7:0] d);
    logic v;
    for (int i = 7; i >= 0; i--) begin
      getBit(v);
      d[i] = v;
    end
    sendBit(~ackIt);
  endtask

  task automatic testReset();
    logic a; logic [7:0] d;
    chk("R11", "sdaOe after reset", int'(sdaOe), 0);
    busStart();
    sendByte(8'hD1, a);  chk("R3", "read address ack", int'(a), 1);
    recvByte(1'b0, d);   chk("R11", "reg0 after reset", int'(d), 8'h00);
    busStop();
  endtask

  task automatic testWrite();
    logic a;
    logic [7:0] vals [3] = '{8'hA1, 8'hB2, 8'hC3};
    busStart();
    sendByte(8'hD0, a);  chk("R3", "write address ack", int'(a), 1);
    sendByte(8'h03, a);  chk("R5", "word address ack", int'(a), 1);
    foreach (vals[i]) begin
      sendByte(vals[i], a); chk("R6", "data byte ack", int'(a), 1);
    end
    busStop();
  endtask

  task automatic testReadPersist();
    logic a; logic [7:0] d;
    busStart();
    sendByte(8'hD0, a); sendByte(8'h03, a);  chk("R5", "pointer-only ack", int'(a), 1);
    busStop();
    busStart();
    sendByte(8'hD1, a);
    recvByte(1'b1, d); chk("R7", "read at pointer 3", int'(d), 8'hA1);
    recvByte(1'b0, d); chk("R7", "read advanced to 4", int'(d), 8'hB2);
    waitQ();
    chk("R8", "sdaOe released after nack", int'(sdaOe), 0);
    chk("R8", "SDA high for stop", int'(sdaIn), 1);
    busStop();
    busStart();
    sendByte(8'hD1, a);
    recvByte(1'b0, d); chk("R11", "pointer kept across STOP", int'(d), 8'hC3);
    busStop();
  endtask

  task automatic testMismatch();
    logic a; logic [7:0] d;
    oeHigh = 0;
    busStart();
    sendByte(8'hA0, a); chk("R4", "foreign write address nack", int'(a), 0);
    sendByte(8'h04, a); chk("R4", "foreign byte nack", int'(a), 0);
    sendByte(8'h55, a);
    busStop();
    busStart();
    sendByte(8'hD3, a); chk("R4", "foreign read address nack", int'(a), 0);
    recvByte(1'b0, d);  chk("R4", "foreign read sees idle line", int'(d), 8'hFF);
    busStop();
    chk("R4", "cycles with sdaOe during foreign transfers", oeHigh, 0);
    busStart();
    sendByte(8'hD1, a);
    recvByte(1'b0, d);  chk("R4", "pointer/regs untouched (reg6)", int'(d), 8'h00);
    busStop();
  endtask

  task automatic testWrapRestart();
    logic a; logic [7:0] d;
    logic [7:0] vals [3] = '{8'h5A, 8'h6B, 8'h7C};
    busStart();
    sendByte(8'hD0, a); sendByte(8'h0E, a);
    foreach (vals[i]) begin
      sendByte(vals[i], a); chk("R10", "write across wrap ack", int'(a), 1);
    end
    busStart();
    sendByte(8'hD0, a); chk("R9", "ack after repeated START", int'(a), 1);
    sendByte(8'h0E, a);
    busStart();
    sendByte(8'hD1, a); chk("R9", "read ack after second repeated START", int'(a), 1);
    recvByte(1'b1, d); chk("R10", "reg14", int'(d), 8'h5A);
    recvByte(1'b1, d); chk("R10", "reg15", int'(d), 8'h6B);
    recvByte(1'b0, d); chk("R10", "wrapped to reg0", int'(d), 8'h7C);
    busStop();
  endtask

  task automatic testResetMid();
    logic a; logic [7:0] d;
    busStart();
    sendByte(8'hD0, a); sendByte(8'h09, a);
    rst = 1'b1; repeat (4) @(negedge clk);
    rst = 1'b0;
    chk("R11", "sdaOe after mid reset", int'(sdaOe), 0);
    mSda = 1'b1; waitQ();
    mScl = 1'b1; waitQ();
    busStart();
    sendByte(8'hD1, a);
    recvByte(1'b0, d); chk("R11", "reset cleared reg0 and pointer", int'(d), 8'h00);
    busStop();
    chk("R2", "sdaOe changes while SCL high", edgeViol, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    testReset();
    testWrite();
    testReadPersist();
    testMismatch();
    testWrapRestart();
    testResetMid();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nErrors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

endmodule